// File: doc/BRIEF.md
# Byte-Serial Command Port Decoder

This block sits on a narrow command path and turns a stream of bytes into register writes. A command starts with a marker pulse, `cmd_first`, which comes together with the low address byte. The high address byte arrives on the next clock, then one data byte per clock, least significant first. The block rebuilds the address and a 32-bit word from these bytes. It compares the lower 11 address bits against three masked windows: absolute writes, relative writes and the control pair. A completed command to a matching window produces one write pulse, together with a one-hot window flag, the offset inside the window and the assembled data.

Each window has its own data length, set by a parameter of 1 to 4 bytes. After the last byte of that length the sequencer returns to idle, and any further bytes are ignored until the next marker. The sequencer has three states:

- `ST_IDLE`: waiting for a marker.
- `ST_ADDR_HI`: takes the high address byte and decides the window.
- `ST_DATA`: collects the data bytes.

Its transitions are:

- START: `ST_IDLE` to `ST_ADDR_HI` on a marker.
- MATCH: `ST_ADDR_HI` to `ST_DATA` when a window hits.
- MISS: `ST_ADDR_HI` to `ST_IDLE` when no window hits.
- NEXT: `ST_DATA` stays in `ST_DATA` on a byte that is not the last.
- DONE: `ST_DATA` to `ST_IDLE` on the last byte.
- RESTART: any state to `ST_ADDR_HI` on a marker.

Top module: `cmd_port_decoder`

## Requirements
- R1: During and after reset, `wr_pulse` is 0, `win_hit` is 0, and `wr_data` and `wr_offset` are 0. A command cut off by reset produces no pulse when its remaining bytes arrive.
- R2: The first byte is address bits [7:0] and the second is address bits [15:8]. Data byte k lands in `wr_data[8k+7:8k]`. Lanes beyond the window's length read 0.
- R3: An address with (addr & 0x7F0) == 0x300 selects the absolute window. It sets `win_hit` = 3'b001 with `wr_offset` = addr[3:0] and takes 4 data bytes.
- R4: An address with (addr & 0x7F0) == 0x310 selects the relative window. It sets `win_hit` = 3'b010 with `wr_offset` = addr[3:0] and takes 2 data bytes.
- R5: An address with (addr & 0x7FE) == 0x320 selects the control pair. It sets `win_hit` = 3'b100 with `wr_offset` = {3'b000, addr[0]}, where 0 is the control register and 1 is the status register, and takes 4 data bytes.
- R6: Address bits [15:11] have no effect on matching or on the offset.
- R7: `wr_pulse` is high for exactly one cycle, the cycle after the window's last data byte is sampled. `win_hit` is nonzero only in that cycle.
- R8: A marker in the middle of a command drops the partial command. Its byte starts a new command.
- R9: An address that hits no window produces no pulse, and the bytes that follow it are ignored.
- R10: Bytes without a marker while idle, including extra bytes after a completed command, produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command byte stream |
| cmd_first | input | 1 | Marks the first (low address) byte of a command |
| win_hit | output | 3 | One-hot window flag: bit0 absolute, bit1 relative, bit2 control |
| wr_offset | output | 4 | Register offset inside the hit window |
| wr_data | output | 32 | Assembled data word |
| wr_pulse | output | 1 | One-cycle write strobe |

## Verification
A wrong sequencer state shows up at the ports in the cycle after the command's last byte. A lost or stray state gives a missing, doubled or spurious `wr_pulse`. A byte counter that is off by one moves the pulse a cycle early or late, and the wrong byte lands in a data lane. A stale window or offset register gives a wrong `win_hit` bit or offset in the same cycle as the pulse. The abort and miss cases are checked by counting pulses over the idle cycles that follow.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR_HI = 2'd1,
        ST_DATA    = 2'd2
    } seq_state_t;

    localparam int NUM_WIN = 3;

endpackage

// File: rtl/cmd_win_match.sv
module cmd_win_match #(
    parameter int              ADDR_W = 11,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_M = BASE & MASK;

    always_comb hit = ((addr & MASK) == BASE_M);
endmodule

// File: rtl/cmd_data_pack.sv
module cmd_data_pack #(
    parameter int BYTES = 4,
    parameter int CNT_W = 2,
    localparam int DATA_W = BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [CNT_W-1:0]  lane,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] data_out
);
    logic [7:0] lane_q [BYTES];

    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear)
                lane_q[l] <= '0;
            else if (load && lane == CNT_W'(l))
                lane_q[l] <= byte_in;
        end
        assign data_out[l*8 +: 8] = lane_q[l];
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (data_out == '0));
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmd_dec_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             addr_hit,
    input  logic [CNT_W-1:0] last_idx,
    output seq_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             load_addr,
    output logic             take_byte,
    output logic             done
);
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (strobe) begin
            state_d = ST_ADDR_HI;                       // START / RESTART
        end else begin
            unique case (state)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ADDR_HI: state_d = addr_hit ? ST_DATA : ST_IDLE;  // MATCH / MISS
                ST_DATA:    state_d = (cnt == last_idx) ? ST_IDLE : ST_DATA; // DONE / NEXT
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_addr = 1'b0;
        take_byte = 1'b0;
        done      = 1'b0;
        if (!strobe) begin
            unique case (state)
                ST_ADDR_HI: load_addr = addr_hit;
                ST_DATA: begin
                    take_byte = 1'b1;
                    done      = (cnt == last_idx);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load_addr) cnt <= '0;
        else if (take_byte)   cnt <= cnt + 1'b1;
    end

    // R8
    restart_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (state == ST_ADDR_HI));
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (cnt <= last_idx));
    // R9
    miss_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_HI && !strobe && !addr_hit) |=> (state == ST_IDLE));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !strobe) |=> (state == ST_IDLE));
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
    import cmd_dec_pkg::*;
#(
    parameter int                ADDR_W     = 11,
    parameter int                OFS_W      = 4,
    parameter int                DATA_BYTES = 4,
    parameter logic [ADDR_W-1:0] ABS_BASE   = 11'h300,
    parameter logic [ADDR_W-1:0] REL_BASE   = 11'h310,
    parameter logic [ADDR_W-1:0] GRP_MASK   = 11'h7F0,
    parameter logic [ADDR_W-1:0] CTL_BASE   = 11'h320,
    parameter logic [ADDR_W-1:0] CTL_MASK   = 11'h7FE,
    parameter int                ABS_BYTES  = 4,
    parameter int                REL_BYTES  = 2,
    parameter int                CTL_BYTES  = 4,
    localparam int               DATA_W     = DATA_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cmd_byte,
    input  logic               cmd_first,
    output logic [NUM_WIN-1:0] win_hit,
    output logic [OFS_W-1:0]   wr_offset,
    output logic [DATA_W-1:0]  wr_data,
    output logic               wr_pulse
);
    localparam int CNT_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [ADDR_W-1:0] WIN_BASE [NUM_WIN] = '{ABS_BASE, REL_BASE, CTL_BASE};
    localparam logic [ADDR_W-1:0] WIN_MASK [NUM_WIN] = '{GRP_MASK, GRP_MASK, CTL_MASK};
    localparam int                WIN_LEN  [NUM_WIN] = '{ABS_BYTES, REL_BYTES, CTL_BYTES};

    logic [7:0]         addr_lo_q;
    logic [15:0]        addr_full;
    logic [ADDR_W-1:0]  addr_win;
    logic [NUM_WIN-1:0] hit_raw, sel_d, sel_q;
    logic [OFS_W-1:0]   ofs_d, ofs_q;
    logic [CNT_W-1:0]   last_d, last_q, cnt;
    logic               any_hit, load_addr, take_byte, done;
    seq_state_t         fsm_state;

    always_ff @(posedge clk) begin
        if (rst)            addr_lo_q <= '0;
        else if (cmd_first) addr_lo_q <= cmd_byte;
    end

    assign addr_full = {cmd_byte, addr_lo_q};
    assign addr_win  = addr_full[ADDR_W-1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        cmd_win_match #(
            .ADDR_W (ADDR_W),
            .BASE   (WIN_BASE[g]),
            .MASK   (WIN_MASK[g])
        ) u_match (
            .addr (addr_win),
            .hit  (hit_raw[g])
        );
    end

    // lowest window index wins when windows overlap
    always_comb begin
        sel_d  = '0;
        ofs_d  = '0;
        last_d = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_raw[i]) begin
                sel_d    = '0;
                sel_d[i] = 1'b1;
                ofs_d    = addr_win[OFS_W-1:0] & ~WIN_MASK[i][OFS_W-1:0];
                last_d   = CNT_W'(WIN_LEN[i] - 1);
            end
        end
    end
    assign any_hit = |hit_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            ofs_q  <= '0;
            last_q <= '0;
        end else if (load_addr) begin
            sel_q  <= sel_d;
            ofs_q  <= ofs_d;
            last_q <= last_d;
        end
    end

    cmd_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (cmd_first),
        .addr_hit  (any_hit),
        .last_idx  (last_q),
        .state     (fsm_state),
        .cnt       (cnt),
        .load_addr (load_addr),
        .take_byte (take_byte),
        .done      (done)
    );

    cmd_data_pack #(.BYTES(DATA_BYTES), .CNT_W(CNT_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clear    (load_addr),
        .load     (take_byte),
        .lane     (cnt),
        .byte_in  (cmd_byte),
        .data_out (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pulse <= 1'b0;
            win_hit  <= '0;
        end else begin
            wr_pulse <= done;
            win_hit  <= done ? sel_q : '0;
        end
    end
    assign wr_offset = ofs_q;

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
    // R7
    pulse_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> ($past(fsm_state) == ST_DATA));
    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $onehot(win_hit));
    // R7
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |-> (win_hit == '0));
endmodule

// File: tb/cmd_port_decoder_tb_top.sv
module cmd_port_decoder_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_first = 1'b0;
    logic [2:0]  win_hit;
    logic [3:0]  wr_offset;
    logic [31:0] wr_data;
    logic        wr_pulse;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_port_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_byte  (cmd_byte),
        .cmd_first (cmd_first),
        .win_hit   (win_hit),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .wr_pulse  (wr_pulse)
    );

    always @(negedge clk) if (wr_pulse) pulse_cnt++;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
        logic [2:0]  n;
        logic [2:0]  hit;
        logic [3:0]  off;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{16'h0305, 32'h11223344, 3'd4, 3'b001, 4'h5, 32'h11223344},  // R3
        '{16'h030F, 32'hDEADBEEF, 3'd4, 3'b001, 4'hF, 32'hDEADBEEF},  // R3
        '{16'h0310, 32'h0000CAFE, 3'd2, 3'b010, 4'h0, 32'h0000CAFE},  // R4
        '{16'h031A, 32'h12345678, 3'd2, 3'b010, 4'hA, 32'h00005678},  // R4 R2
        '{16'h0320, 32'h00000081, 3'd4, 3'b100, 4'h0, 32'h00000081},  // R5
        '{16'h0321, 32'hA5A50001, 3'd4, 3'b100, 4'h1, 32'hA5A50001},  // R5
        '{16'hFB07, 32'h0BADF00D, 3'd4, 3'b001, 4'h7, 32'h0BADF00D},  // R6
        '{16'hFB21, 32'h76543210, 3'd4, 3'b100, 4'h1, 32'h76543210},  // R6
        '{16'h0330, 32'h99999999, 3'd4, 3'b000, 4'h0, 32'h0},         // R9
        '{16'h0322, 32'h88888888, 3'd4, 3'b000, 4'h0, 32'h0}          // R9
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic f);
        @(negedge clk);
        cmd_byte  = b;
        cmd_first = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(8'h5A, 1'b0);
    endtask

    // sends a command; returns at the negedge where a pulse would be visible
    task automatic send(input logic [15:0] a, input logic [31:0] d, input int n);
        put(a[7:0], 1'b1);
        put(a[15:8], 1'b0);
        for (int k = 0; k < n; k++) put(d[8*k +: 8], 1'b0);
        put(8'hC3, 1'b0);
    endtask

    task automatic expect_write(input string req, input logic [2:0] hit,
                                input logic [3:0] off, input logic [31:0] d);
        chk(wr_pulse == 1'b1, req, "pulse", 32'(wr_pulse), 32'd1);
        chk(win_hit == hit, req, "win_hit", 32'(win_hit), 32'(hit));
        chk(wr_offset == off, req, "offset", 32'(wr_offset), 32'(off));
        chk(wr_data == d, req, "data", wr_data, d);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(wr_pulse == 1'b0, "R1", "pulse in reset", 32'(wr_pulse), 32'd0);
        chk(win_hit == 3'b000, "R1", "hit in reset", 32'(win_hit), 32'd0);
        chk(wr_data == 32'd0, "R1", "data in reset", wr_data, 32'd0);
        chk(wr_offset == 4'd0, "R1", "offset in reset", 32'(wr_offset), 32'd0);
        rst = 1'b0;
        idle(2);

        // R10 stray bytes without marker
        c0 = pulse_cnt;
        for (int i = 0; i < 6; i++) put(8'h00 + 8'(i * 37), 1'b0);
        idle(2);
        chk(pulse_cnt == c0, "R10", "stray bytes pulsed", 32'(pulse_cnt), 32'(c0));

        // vector table
        for (int v = 0; v < 10; v++) begin
            c0 = pulse_cnt;
            send(VECS[v].addr, VECS[v].data, int'(VECS[v].n));
            if (VECS[v].hit != 3'b000) begin
                expect_write("R2", VECS[v].hit, VECS[v].off, VECS[v].exp);
            end else begin
                chk(wr_pulse == 1'b0, "R9", "miss pulse", 32'(wr_pulse), 32'd0);
            end
            idle(1);
            chk(wr_pulse == 1'b0, "R7", "pulse width", 32'(wr_pulse), 32'd0);
            chk(win_hit == 3'b000, "R7", "hit after pulse", 32'(win_hit), 32'd0);
            idle(1);
            chk(pulse_cnt == c0 + ((VECS[v].hit != 0) ? 1 : 0), "R7", "pulse count",
                32'(pulse_cnt), 32'(c0 + ((VECS[v].hit != 0) ? 1 : 0)));
        end

        // R8 marker during data phase
        c0 = pulse_cnt;
        put(8'h05, 1'b1); put(8'h03, 1'b0); put(8'h11, 1'b0);
        send(16'h0312, 32'h0000BEEF, 2);
        expect_write("R8", 3'b010, 4'h2, 32'h0000BEEF);
        idle(2);
        chk(pulse_cnt == c0 + 1, "R8", "abort count", 32'(pulse_cnt), 32'(c0 + 1));

        // R8 marker during high-address phase
        c0 = pulse_cnt;
        put(8'h00, 1'b1);
        send(16'h0321, 32'h01020304, 4);
        expect_write("R8", 3'b100, 4'h1, 32'h01020304);
        idle(2);
        chk(pulse_cnt == c0 + 1, "R8", "restart count", 32'(pulse_cnt), 32'(c0 + 1));

        // R10 extra bytes after a completed command
        c0 = pulse_cnt;
        send(16'h0311, 32'h0000ABCD, 2);
        expect_write("R10", 3'b010, 4'h1, 32'h0000ABCD);
        for (int i = 0; i < 4; i++) put(8'hE0 + 8'(i), 1'b0);
        idle(2);
        chk(pulse_cnt == c0 + 1, "R10", "extra bytes", 32'(pulse_cnt), 32'(c0 + 1));

        // R1 reset in the middle of a command
        c0 = pulse_cnt;
        put(8'h04, 1'b1); put(8'h03, 1'b0); put(8'hAA, 1'b0); put(8'hBB, 1'b0);
        @(negedge clk); rst = 1'b1; cmd_first = 1'b0;
        @(negedge clk);
        chk(wr_data == 32'd0, "R1", "data cleared", wr_data, 32'd0);
        rst = 1'b0;
        put(8'hCC, 1'b0); put(8'hDD, 1'b0);
        idle(3);
        chk(pulse_cnt == c0, "R1", "reset abort", 32'(pulse_cnt), 32'(c0));

        // after reset a full command still works
        send(16'h0300, 32'hCAFEF00D, 4);
        expect_write("R3", 3'b001, 4'h0, 32'hCAFEF00D);
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule